// File: doc/BRIEF.md
# GCM Pre-Counter Block Generator

This block derives the initial counter block J0 of Galois/Counter Mode from an initialization vector of any byte length. It also derives the first counter used for the data keystream. A 12-byte IV takes a direct path: J0 is the IV with a 32-bit big-endian one appended, and no hashing is done. Any other length is folded through GHASH under the hash subkey H. The IV is treated as zero-padded to whole 16-byte blocks, and a final block carries the IV length in bits.

A transfer begins with a `start` pulse carrying the IV length in bytes. The IV then arrives as 16-byte blocks over a valid/ready pair, with the first IV byte in the top byte lane. Each block is multiplied by H one bit per cycle, so `iv_ready` is held low while a product is in progress. When the result is stable, `done` pulses for one cycle. `j0` keeps the value meant for encrypting the tag, and `ctr_first` gives the counter that opens the data stream. The hash subkey must be held constant from `start` to `done`. Producing H and running the block cipher are left to the surrounding logic.

Top module: `gcm_j0_gen`

## Requirements
- R1: After reset, `done` and `iv_ready` are 0, `j0` is all zeros and `ctr_first` is 1.
- R2: For an IV length of 12 bytes, exactly one block is taken. `j0` equals the 12 IV bytes (byte 0 at bits 127:120) followed by 32'h00000001, and `done` rises no more than 3 cycles after the `start` cycle, with no hashing.
- R3: For any other length n ≥ 1, exactly ceil(n/16) IV blocks are requested. The accumulator starts at zero, and each block updates it as X = (X xor block)·H. A product takes 128 cycles, so the run from `start` to `done` lasts more than 128·(ceil(n/16)+1) cycles.
- R4: In the last IV block, byte lanes at positions n and above (byte k sits at bits 127-8k down to 120-8k) are treated as zero whatever `iv_data` carries there.
- R5: After the IV blocks, one more block is hashed. Its upper 64 bits are zero and its lower 64 bits hold 8·n as a big-endian count. The result of that block is `j0`.
- R6: `ctr_first` equals `j0` with bits 127:32 unchanged and bits 31:0 incremented by one modulo 2^32.
- R7: `done` is a single-cycle pulse. `j0` changes only on the edge that raises `done`, and then holds until a later transfer completes.
- R8: `iv_ready` is high only while the block waits for an IV block. It drops on the cycle after a block is accepted and is never high while `done` is high.
- R9: A `start` with length 0 is ignored, and so is a `start` that arrives while a transfer is in progress. Neither changes the next result.
- R10: Multiplication in GF(2^128) uses the bit-reflected convention (bit 127 of a word is the coefficient of x^0) and reduces by x^128 + x^7 + x^2 + x + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| iv_len | input | LEN_W | IV length in bytes, sampled with `start` |
| h_key | input | 128 | Hash subkey H, held during a transfer |
| iv_valid | input | 1 | An IV block is offered |
| iv_data | input | 128 | IV block, first byte in bits 127:120 |
| iv_ready | output | 1 | Block can accept an IV block |
| j0 | output | 128 | Pre-counter block for the tag keystream |
| ctr_first | output | 128 | J0 with low word incremented, first data counter |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench sweeps every IV length from 1 to 40 bytes and adds 44, 48 and 64, so each count of remaining bytes in the last block is covered, along with the 16-byte multiples. A design that padded wrongly, dropped the length block or miscounted blocks would give a wrong J0, or would ask for an extra block. Every byte past the IV length is filled with nonzero junk, so a design that fails to mask the padding gives a different hash. The 12-byte case is checked for timing as well as value, which catches a design that hashes it anyway. A block whose low word sums to all ones under an identity subkey forces the counter increment to wrap, which exposes a carry leaking into bit 32. A zero-length start and a start during a transfer are both applied, and the results are checked to be unchanged.

// File: rtl/gcmj0_pkg.sv
package gcmj0_pkg;
    localparam int BLK_BITS  = 128;
    localparam int BLK_BYTES = BLK_BITS / 8;
    localparam int WORD_BITS = 32;
    localparam int FAST_LEN  = 12;

    typedef logic [BLK_BITS-1:0] blk_t;

    typedef struct packed {
        logic [BLK_BITS-WORD_BITS-1:0] fixed;
        logic [WORD_BITS-1:0]          word;
    } ctr_blk_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LEN,
        ST_HASH,
        ST_DONE
    } st_t;

    localparam blk_t REDUCE = {8'hE1, {(BLK_BITS-8){1'b0}}};

    // One step of the reflected shift: multiply V by x and reduce.
    function automatic blk_t gf_halve(blk_t v);
        return v[0] ? ((v >> 1) ^ REDUCE) : (v >> 1);
    endfunction

    function automatic blk_t len_block(logic [63:0] bits);
        return {64'b0, bits};
    endfunction
endpackage

// File: rtl/gcmj0_gfmul.sv
module gcmj0_gfmul
    import gcmj0_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  blk_t x,
    input  blk_t y,
    output logic done,
    output blk_t z
);
    localparam int CNT_W = $clog2(BLK_BITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_BITS - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    blk_t             xs;
    blk_t             v;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
            xs   <= '0;
            v    <= '0;
            z    <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                xs   <= x;
                v    <= y;
                z    <= '0;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (xs[BLK_BITS-1]) begin
                    z <= z ^ v;
                end
                v   <= gf_halve(v);
                xs  <= xs << 1;
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/gcmj0_pad.sv
module gcmj0_pad
    import gcmj0_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0] remain,
    input  blk_t             din,
    output blk_t             dout
);
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
        assign dout[BLK_BITS-1-8*b -: 8] =
            (remain > LEN_W'(b)) ? din[BLK_BITS-1-8*b -: 8] : 8'h00;
    end
endmodule

// File: rtl/gcmj0_inc.sv
module gcmj0_inc
    import gcmj0_pkg::*;
(
    input  blk_t j0_in,
    output blk_t ctr_out
);
    ctr_blk_t src;
    ctr_blk_t nxt;

    always_comb begin
        src       = ctr_blk_t'(j0_in);
        nxt.fixed = src.fixed;
        nxt.word  = src.word + 1'b1;
    end

    assign ctr_out = blk_t'(nxt);
endmodule

// File: rtl/gcm_j0_gen.sv
module gcm_j0_gen
    import gcmj0_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] iv_len,
    input  logic [127:0]     h_key,
    input  logic             iv_valid,
    input  logic [127:0]     iv_data,
    output logic             iv_ready,
    output logic [127:0]     j0,
    output logic [127:0]     ctr_first,
    output logic             done
);
    localparam logic [LEN_W-1:0] STEP  = LEN_W'(BLK_BYTES);
    localparam logic [LEN_W-1:0] FASTN = LEN_W'(FAST_LEN);

    st_t              st;
    blk_t             acc;
    blk_t             j0_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] left_q;
    logic             fast_q;
    logic             lenph_q;

    blk_t iv_pad;
    blk_t mul_x;
    blk_t mul_z;
    logic mul_go;
    logic mul_done;

    gcmj0_pad #(.LEN_W(LEN_W)) u_pad (
        .remain (left_q),
        .din    (iv_data),
        .dout   (iv_pad)
    );

    always_comb begin
        mul_go = 1'b0;
        mul_x  = acc ^ iv_pad;
        if (st == ST_LEN) begin
            mul_go = 1'b1;
            mul_x  = acc ^ len_block(64'(len_q) << 3);
        end else if (st == ST_FETCH && iv_valid && !fast_q) begin
            mul_go = 1'b1;
        end
    end

    gcmj0_gfmul u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (mul_go),
        .x    (mul_x),
        .y    (h_key),
        .done (mul_done),
        .z    (mul_z)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            acc     <= '0;
            j0_q    <= '0;
            len_q   <= '0;
            left_q  <= '0;
            fast_q  <= 1'b0;
            lenph_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start && iv_len != '0) begin
                        len_q   <= iv_len;
                        left_q  <= iv_len;
                        fast_q  <= (iv_len == FASTN);
                        acc     <= '0;
                        lenph_q <= 1'b0;
                        st      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (iv_valid) begin
                        if (fast_q) begin
                            j0_q <= {iv_pad[BLK_BITS-1:WORD_BITS], WORD_BITS'(1)};
                            st   <= ST_DONE;
                        end else begin
                            left_q <= (left_q > STEP) ? left_q - STEP : '0;
                            st     <= ST_HASH;
                        end
                    end
                end
                ST_LEN: begin
                    lenph_q <= 1'b1;
                    st      <= ST_HASH;
                end
                ST_HASH: begin
                    if (mul_done) begin
                        acc <= mul_z;
                        if (lenph_q) begin
                            j0_q <= mul_z;
                            st   <= ST_DONE;
                        end else if (left_q == '0) begin
                            st <= ST_LEN;
                        end else begin
                            st <= ST_FETCH;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    gcmj0_inc u_inc (
        .j0_in   (j0_q),
        .ctr_out (ctr_first)
    );

    assign j0       = j0_q;
    assign iv_ready = (st == ST_FETCH);
    assign done     = (st == ST_DONE);
endmodule

// File: rtl/gcmj0_chk.sv
module gcmj0_chk
    import gcmj0_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] iv_len,
    input logic             iv_valid,
    input logic             iv_ready,
    input logic             done,
    input logic [127:0]     j0,
    input st_t              st
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_j0_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(j0));

    p_one_block_r8: assert property (@(posedge clk) disable iff (rst)
        (iv_ready && iv_valid) |=> !iv_ready);

    p_no_ready_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !iv_ready);

    p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && iv_len == '0) |=> (st == ST_IDLE));
endmodule

bind gcm_j0_gen gcmj0_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .iv_len   (iv_len),
    .iv_valid (iv_valid),
    .iv_ready (iv_ready),
    .done     (done),
    .j0       (j0),
    .st       (st)
);

// File: tb/test_gcm_j0_gen.sv
module test_gcm_j0_gen;
    import gcmj0_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] iv_len = '0;
    blk_t             h_key = '0;
    logic             iv_valid = 1'b0;
    blk_t             iv_data = '0;
    logic             iv_ready;
    blk_t             j0;
    blk_t             ctr_first;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] ivb [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    gcm_j0_gen #(.LEN_W(LEN_W)) i_gcm_j0_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .iv_len    (iv_len),
        .h_key     (h_key),
        .iv_valid  (iv_valid),
        .iv_data   (iv_data),
        .iv_ready  (iv_ready),
        .j0        (j0),
        .ctr_first (ctr_first),
        .done      (done)
    );

    task automatic chk(bit ok, string req, blk_t act, blk_t exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Field multiply by the textbook definition (R10).
    function automatic blk_t gmul(blk_t a, blk_t b);
        blk_t zz = '0;
        blk_t vv = b;
        for (int i = 0; i < 128; i++) begin
            if (a[127-i]) zz ^= vv;
            vv = vv[0] ? ((vv >> 1) ^ {8'hE1, 120'h0}) : (vv >> 1);
        end
        return zz;
    endfunction

    function automatic blk_t make_blk(int len, int k, bit junk);
        blk_t b = '0;
        for (int i = 0; i < 16; i++) begin
            int idx = k*16 + i;
            if (idx < len) b[127-8*i -: 8] = ivb[idx];
            else if (junk) b[127-8*i -: 8] = 8'hA5 ^ 8'(idx);
        end
        return b;
    endfunction

    function automatic blk_t model_j0(int len, blk_t h);
        blk_t a = '0;
        int nb = (len + 15) / 16;
        if (len == 12) begin
            a = make_blk(len, 0, 1'b0);
            return {a[127:32], 32'h1};
        end
        for (int k = 0; k < nb; k++) a = gmul(a ^ make_blk(len, k, 1'b0), h);
        a = gmul(a ^ {64'h0, 64'(len) * 64'd8}, h);
        return a;
    endfunction

    task automatic fill_ivb(int len, int seed);
        for (int i = 0; i < 64; i++) ivb[i] = 8'(i*37 + len*11 + seed*5 + 3);
    endtask

    task automatic run_case(int len, blk_t h, blk_t exp, bit poke);
        int nb = (len + 15) / 16;
        int cyc = 0;
        int wait_n;
        bit extra = 1'b0;
        bit timeout = 1'b0;
        blk_t held;
        h_key = h;
        @(negedge clk);
        start = 1'b1;
        iv_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        iv_len = '0;
        cyc = 1;
        for (int k = 0; k < nb; k++) begin
            wait_n = 0;
            while (!iv_ready && wait_n < 1000) begin
                @(negedge clk);
                cyc++;
                wait_n++;
            end
            if (!iv_ready) timeout = 1'b1;
            iv_valid = 1'b1;
            iv_data = make_blk(len, k, 1'b1);
            @(negedge clk);
            cyc++;
            iv_valid = 1'b0;
            iv_data = '1;
            chk(!iv_ready, "R8 ready drops after accept", blk_t'(iv_ready), '0);
            if (poke && k == 0) begin
                start = 1'b1;
                iv_len = LEN_W'(7);
                @(negedge clk);
                cyc++;
                start = 1'b0;
                iv_len = '0;
            end
        end
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            if (iv_ready) extra = 1'b1;
            @(negedge clk);
            cyc++;
            wait_n++;
        end
        if (!done) timeout = 1'b1;
        chk(!timeout && !extra, "R3 block count", blk_t'({extra, timeout}), '0);
        chk(j0 === exp, poke ? "R9 start while busy" : "R3 R4 R5 j0 value", j0, exp);
        chk(ctr_first === {exp[127:32], exp[31:0] + 32'd1}, "R6 first counter",
            ctr_first, {exp[127:32], exp[31:0] + 32'd1});
        if (len == 12)
            chk(cyc <= 3, "R2 fast path latency", blk_t'(cyc), blk_t'(3));
        else
            chk(cyc > 128*(nb+1), "R3 hash latency", blk_t'(cyc), blk_t'(128*(nb+1)));
        held = j0;
        @(negedge clk);
        chk(!done, "R7 done single cycle", blk_t'(done), '0);
        repeat (3) @(negedge clk);
        chk(j0 === held && !iv_ready, "R7 j0 held", j0, held);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        blk_t e;
        blk_t hh;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !iv_ready && j0 == '0, "R1 reset outputs", j0, '0);
        chk(ctr_first == 128'h1, "R1 reset counter", ctr_first, 128'h1);

        // R9: zero length start is ignored
        @(negedge clk);
        start = 1'b1;
        iv_len = '0;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(!iv_ready && !done, "R9 zero length ignored",
            blk_t'({iv_ready, done}), '0);

        // Sweep of lengths (R2 R3 R4 R5 R10)
        for (int len = 1; len <= 64; len++) begin
            if (len <= 40 || len == 44 || len == 48 || len == 64) begin
                fill_ivb(len, 1);
                hh = {32'h66e94bd4 ^ 32'(len), 32'hef8a2c3b, 32'h884cfa59 + 32'(len), 32'hca342b2e};
                e = model_j0(len, hh);
                run_case(len, hh, e, 1'b0);
            end
        end

        // R9: start during a transfer does not disturb it
        fill_ivb(30, 7);
        hh = 128'hb83b533708bf535d0aa6e52980d53b78;
        e = model_j0(30, hh);
        run_case(30, hh, e, 1'b1);

        // R6 wrap: identity subkey makes GHASH a plain XOR of blocks
        for (int i = 0; i < 12; i++) ivb[i] = 8'(8'h10 + i);
        ivb[12] = 8'hFF;
        ivb[13] = 8'hFF;
        ivb[14] = 8'hFF;
        ivb[15] = 8'h7F;
        e = make_blk(16, 0, 1'b0) ^ {64'h0, 64'd128};
        chk(e[31:0] == 32'hFFFFFFFF, "R6 wrap setup", e, e);
        run_case(16, {1'b1, 127'h0}, e, 1'b0);
        chk(ctr_first[31:0] == 32'h0 && ctr_first[127:32] == e[127:32],
            "R6 wrap no carry", ctr_first, {e[127:32], 32'h0});

        report();
        $finish;
    end
endmodule